// File: doc/BRIEF.md
# Infrared Raw Symbol Capture Receiver

This block watches a demodulated infrared line and turns it into timed symbols. The line rests high. A symbol opens when the line falls, and the block counts its low phase and then its high phase in fixed ticks. Each tick is ten microseconds long: a prescaler is told the input clock rate in MHz, minus one. A symbol closes when the line falls again, which also opens the next symbol. A symbol also closes when its high phase has lasted a programmed maximum width. In that case the stream is treated as ended and a timeout event is raised. Closed symbols are written into a 16-entry receive FIFO as one word each.

Software drives the block through a small register bus. It first writes enable, waits until busy drops, programs the configuration, and then writes the start register. The block raises one interrupt line for three events: symbols waiting, the line idle past the maximum width, and a symbol lost to a full FIFO. Each event has a mask, a sticky status bit and a write-one-to-clear bit. On overflow the stored symbols are kept. Software reads them out before the overflow status can be cleared.

Register byte offsets:

| Offset | Register |
|---|---|
| 0x00 | enable |
| 0x04 | config |
| 0x08 | busy |
| 0x0C | start |
| 0x10 | symbol count |
| 0x14 | pop |
| 0x18 | mask |
| 0x1C | status |
| 0x20 | clear |

Config fields:

| Bits | Field | Reset value |
|---|---|---|
| 31:16 | maximum width, in ticks | 0x3E80 |
| 15:14 | symbol format | 0 |
| 13:8 | interrupt threshold minus one | 0 |
| 7 | raw-mode enable | 1 |
| 6:0 | clock MHz minus one | 0 |

The config register therefore resets to 0x3E800080.

Top module: `irrx_top`

## Requirements
- R1: After reset the following hold:
  - irq is 0;
  - busy reads 0;
  - symbol count reads 0;
  - status reads 0;
  - config reads 0x3E800080.
- R2: Writing 1 to bit 0 of enable makes busy (bit 0 of 0x08) read 1 for 8 clock cycles, after which it reads 0. A start write made while busy is high is ignored.
- R3: Each FIFO word holds the low-phase tick count in bits 15:0 and the high-phase tick count in bits 31:16. A phase that lasts N clock cycles counts floor(N/T) ticks, where T = (clock field + 1) × 10. Counts saturate at 0xFFFF.
- R4: When the high phase reaches the maximum width, the symbol is stored with its high field equal to the maximum width. The timeout status is set: bit 9, and bit 25 while unmasked. The next falling edge opens a new stream.
- R5: The count register returns the number of stored symbols. Each read of the pop register returns the oldest symbol and removes it. A pop read of an empty FIFO returns 0.
- R6: A symbol that closes while the FIFO holds 16 entries is dropped and sets overflow status (bits 10 and 26). The 16 stored symbols are kept intact and in order.
- R7: A write of 1 to clear bit 18 is ignored while the FIFO holds any symbol. It clears overflow once the FIFO is empty.
- R8: Writing 1 to clear bits 16, 17 or 18 clears only the receive, timeout or overflow status, respectively.
- R9: Mask bits 0, 1 and 2 (receive, timeout, overflow), when set, suppress that event's status bit in 26:24 and its contribution to irq. Status bits 10:8 still record the event. irq is the OR of status bits 26:24.
- R10: Receive status (bits 8 and 24) is set only when a stored symbol brings the count to at least the threshold field plus one.
- R11: No symbol is measured or stored before a start write accepted after enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_in | input | 1 | Demodulated infrared line, idle high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a read of pop removes a symbol |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, valid in the same cycle |
| irq | output | 1 | Interrupt request |

## Verification
Phases are driven with lengths that are not whole multiples of the tick, so the count must be the floor. A design that rounds, or that drops or double-counts the tick on the edge cycle, stores words one tick off.

The stream is ended by a long high phase. A design that misses the timeout never stores the last symbol, or stores a high count other than the maximum width.

Seventeen symbols are sent into the 16-entry FIFO. A design that flushes or overwrites on overflow returns the wrong words. A design that accepts the overflow clear while symbols remain loses the status.

The threshold and mask cases check the interrupt and status logic:
- a design that sets receive status on every store raises it too early;
- a design that masks the raw status bits loses the record of a masked event;
- a design that clears the wrong event on a write to the clear register loses an event that was never cleared.

// File: rtl/irrx_pkg.sv
package irrx_pkg;

    localparam logic [5:0] A_ENABLE = 6'h00;
    localparam logic [5:0] A_CFG    = 6'h04;
    localparam logic [5:0] A_BUSY   = 6'h08;
    localparam logic [5:0] A_GO     = 6'h0C;
    localparam logic [5:0] A_LEVEL  = 6'h10;
    localparam logic [5:0] A_POP    = 6'h14;
    localparam logic [5:0] A_MASK   = 6'h18;
    localparam logic [5:0] A_STAT   = 6'h1C;
    localparam logic [5:0] A_CLR    = 6'h20;

    typedef struct packed {
        logic [15:0] maxw;
        logic [1:0]  fmt;
        logic [5:0]  lvl;
        logic        raw;
        logic [6:0]  freq;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{maxw: 16'h3E80, fmt: 2'd0, lvl: 6'd0, raw: 1'b1, freq: 7'd0};

    typedef struct packed {
        logic [15:0] hi;
        logic [15:0] lo;
    } sym_t;

    typedef struct packed {
        logic ovf;
        logic tmo;
        logic rcv;
    } evt_t;

    typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_e;

    function automatic logic [15:0] sat_inc(input logic [15:0] v, input logic inc);
        return (inc && v != 16'hFFFF) ? v + 16'd1 : v;
    endfunction

endpackage

// File: rtl/irrx_sync_edge.sv
module irrx_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-1:0], din};
    end

    assign lvl  = sh[STAGES-1];
    assign rise = sh[STAGES-1] & ~sh[STAGES];
    assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/irrx_tick.sv
module irrx_tick #(
    parameter int TICK_US = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [6:0] freq,
    input  logic       restart,
    output logic       tick
);
    localparam int CW = $clog2(128 * TICK_US) + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] period;

    assign period = CW'((32'(freq) + 32'd1) * 32'(TICK_US));
    assign tick   = (cnt == period - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || restart || tick) cnt <= '0;
        else                        cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/irrx_measure.sv
module irrx_measure
    import irrx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        arm,
    input  logic        rise,
    input  logic        fall,
    input  logic        tick,
    input  logic [15:0] maxw,
    output logic        push,
    output sym_t        word,
    output logic        tmo_evt
);
    phase_e      ph;
    logic [15:0] lo_cnt, hi_cnt;
    logic [15:0] lo_nxt, hi_nxt;

    assign lo_nxt = sat_inc(lo_cnt, tick);
    assign hi_nxt = sat_inc(hi_cnt, tick);

    always_comb begin
        push    = 1'b0;
        tmo_evt = 1'b0;
        word    = '{hi: hi_nxt, lo: lo_cnt};
        if (arm && ph == PH_HIGH) begin
            if (fall) begin
                push = 1'b1;
            end else if (hi_nxt >= maxw) begin
                push    = 1'b1;
                tmo_evt = 1'b1;
                word.hi = maxw;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !arm) begin
            ph     <= PH_IDLE;
            lo_cnt <= '0;
            hi_cnt <= '0;
        end else begin
            unique case (ph)
                PH_IDLE: if (fall) begin
                    ph     <= PH_LOW;
                    lo_cnt <= '0;
                end
                PH_LOW: begin
                    lo_cnt <= lo_nxt;
                    if (rise) begin
                        ph     <= PH_HIGH;
                        hi_cnt <= '0;
                    end
                end
                PH_HIGH: begin
                    hi_cnt <= hi_nxt;
                    if (fall) begin
                        ph     <= PH_LOW;
                        lo_cnt <= '0;
                    end else if (tmo_evt) begin
                        ph <= PH_IDLE;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/irrx_fifo.sv
module irrx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = empty ? '0 : mem[rp];

    function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= adv(wp);
            if (do_pop)  rp <= adv(rp);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/irrx_top.sv
module irrx_top
    import irrx_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int TICK_US     = 10,
    parameter int BUSY_CYCLES = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ir_in,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam int BW   = $clog2(BUSY_CYCLES + 1);

    cfg_t            cfg;
    evt_t            mask, sts_raw, sts_msk, clr;
    logic            en, running, busy, arm;
    logic [BW-1:0]   busy_cnt;
    logic            line, rise, fall, tick;
    logic            push, tmo_evt;
    sym_t            push_word;
    logic [31:0]     head;
    logic [CNTW-1:0] fifo_cnt;
    logic            fifo_full, fifo_empty, pop;
    logic            wr_en, wr_go, wr_clr;

    assign busy    = (busy_cnt != '0);
    assign arm     = running && cfg.raw;
    assign wr_en   = bus_wr && bus_addr == A_ENABLE;
    assign wr_go   = bus_wr && bus_addr == A_GO;
    assign wr_clr  = bus_wr && bus_addr == A_CLR;
    assign clr     = wr_clr ? evt_t'(bus_wdata[18:16]) : '0;
    assign pop     = bus_rd && bus_addr == A_POP;
    assign sts_msk = sts_raw & ~mask;
    assign irq     = |sts_msk;

    irrx_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(ir_in), .lvl(line), .rise(rise), .fall(fall)
    );

    irrx_tick #(.TICK_US(TICK_US)) u_tick (
        .clk(clk), .rst(rst), .freq(cfg.freq), .restart(rise | fall), .tick(tick)
    );

    irrx_measure u_meas (
        .clk(clk), .rst(rst), .arm(arm), .rise(rise), .fall(fall), .tick(tick),
        .maxw(cfg.maxw), .push(push), .word(push_word), .tmo_evt(tmo_evt)
    );

    irrx_fifo #(.DEPTH(DEPTH), .W(32)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .wdata(push_word), .pop(pop),
        .rdata(head), .count(fifo_cnt), .full(fifo_full), .empty(fifo_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en       <= 1'b0;
            running  <= 1'b0;
            busy_cnt <= '0;
            cfg      <= CFG_RESET;
            mask     <= '0;
        end else begin
            if (busy) busy_cnt <= busy_cnt - BW'(1);
            if (wr_en) begin
                en       <= bus_wdata[0];
                running  <= 1'b0;
                busy_cnt <= bus_wdata[0] ? BW'(BUSY_CYCLES) : '0;
            end else if (wr_go && en && !busy) begin
                running <= 1'b1;
            end
            if (bus_wr && bus_addr == A_CFG)  cfg  <= cfg_t'(bus_wdata);
            if (bus_wr && bus_addr == A_MASK) mask <= evt_t'(bus_wdata[2:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_raw <= '0;
        end else begin
            if (push && !fifo_full && fifo_cnt >= CNTW'(cfg.lvl)) sts_raw.rcv <= 1'b1;
            else if (clr.rcv)                                      sts_raw.rcv <= 1'b0;
            if (tmo_evt)      sts_raw.tmo <= 1'b1;
            else if (clr.tmo) sts_raw.tmo <= 1'b0;
            if (push && fifo_full)          sts_raw.ovf <= 1'b1;
            else if (clr.ovf && fifo_empty) sts_raw.ovf <= 1'b0;
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_ENABLE: bus_rdata = {31'd0, en};
            A_CFG:    bus_rdata = cfg;
            A_BUSY:   bus_rdata = {31'd0, busy};
            A_LEVEL:  bus_rdata = 32'(fifo_cnt);
            A_POP:    bus_rdata = head;
            A_MASK:   bus_rdata = {29'd0, mask};
            A_STAT:   bus_rdata = {5'd0, sts_msk, 13'd0, sts_raw, 8'd0};
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irrx_chk.sv
module irrx_chk #(
    parameter int DEPTH = 16,
    parameter int CNTW  = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            push,
    input logic            full,
    input logic            empty,
    input logic [15:0]     word_hi,
    input logic [15:0]     maxw,
    input logic [CNTW-1:0] count,
    input logic            ovf_raw,
    input logic            tmo_evt,
    input logic            tmo_raw,
    input logic            arm,
    input logic            busy,
    input logic            running
);
    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CNTW'(DEPTH));

    a_r6_drop_sets_ovf: assert property (@(posedge clk) disable iff (rst)
        push && full |=> ovf_raw);

    a_r7_ovf_held: assert property (@(posedge clk) disable iff (rst)
        ovf_raw && !empty |=> ovf_raw);

    a_r4_tmo_sets: assert property (@(posedge clk) disable iff (rst)
        tmo_evt |=> tmo_raw);

    a_r3_hi_bound: assert property (@(posedge clk) disable iff (rst)
        push |-> word_hi <= maxw);

    a_r11_no_push_unarmed: assert property (@(posedge clk) disable iff (rst)
        !arm |-> !push);

    a_r2_start_after_busy: assert property (@(posedge clk) disable iff (rst)
        busy |=> !$rose(running));
endmodule

bind irrx_top irrx_chk #(.DEPTH(DEPTH), .CNTW(CNTW)) u_chk (
    .clk(clk), .rst(rst), .push(push), .full(fifo_full), .empty(fifo_empty),
    .word_hi(push_word.hi), .maxw(cfg.maxw), .count(fifo_cnt),
    .ovf_raw(sts_raw.ovf), .tmo_evt(tmo_evt), .tmo_raw(sts_raw.tmo),
    .arm(arm), .busy(busy), .running(running)
);

// File: tb/tb_irrx_top.sv
`timescale 1ns/1ps
module tb_irrx_top;
    localparam int T     = 10;
    localparam int MAXW  = 20;
    localparam int DEPTH = 16;

    logic        clk = 0;
    logic        rst = 1;
    logic        ir_in = 1;
    logic        bus_wr = 0, bus_rd = 0;
    logic [5:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0, bad = 0;
    logic [31:0] expq[$];

    irrx_top dut (.clk(clk), .rst(rst), .ir_in(ir_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
                  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

    always #2.5 clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_word(logic [15:0] lo, logic [15:0] hi);
        if (expq.size() < DEPTH) expq.push_back({hi, lo});
    endtask

    task automatic send_sym(int lo, int hi);
        ir_in = 0; idle(lo);
        ir_in = 1; idle(hi);
        expect_word(16'(lo / T), 16'(hi / T));
    endtask

    task automatic end_stream(int lo);
        ir_in = 0; idle(lo);
        ir_in = 1; idle(MAXW * T + 20);
        expect_word(16'(lo / T), 16'(MAXW));
    endtask

    task automatic drain(string req);
        logic [31:0] d;
        rd(8'h10, d);
        check({req, " count"}, d, 32'(expq.size()));
        while (expq.size() > 0) begin
            logic [31:0] e;
            e = expq.pop_front();
            rd(6'h14, d);
            check({req, " word"}, d, e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        idle(5);
        rst = 0;
        idle(2);

        // R1 reset state
        check("R1 irq", {31'd0, irq}, 0);
        rd(6'h08, d); check("R1 busy", d, 0);
        rd(6'h10, d); check("R1 count", d, 0);
        rd(6'h1C, d); check("R1 status", d, 0);
        rd(6'h04, d); check("R1 cfg", d, 32'h3E80_0080);

        // R2 busy window and start blocked while busy
        wr(6'h00, 1);
        rd(6'h08, d); check("R2 busy high", d, 1);
        wr(6'h0C, 1);
        idle(10);
        rd(6'h08, d); check("R2 busy low", d, 0);
        wr(6'h04, {16'(MAXW), 2'd0, 6'd0, 1'b1, 7'd0});

        // R11 nothing captured without an accepted start
        ir_in = 0; idle(40); ir_in = 1; idle(MAXW * T + 20);
        rd(6'h10, d); check("R11 no capture", d, 0);

        wr(6'h0C, 1);
        idle(5);

        // R3 R4 R5 basic stream ended by timeout
        send_sym(57, 33);
        send_sym(40, 70);
        send_sym(19, 121);
        end_stream(25);
        rd(6'h1C, d); check("R4 status rcv+tmo", d, 32'h0300_0300);
        check("R9 irq set", {31'd0, irq}, 1);
        drain("R3 R5");
        rd(6'h14, d); check("R5 empty pop", d, 0);
        wr(6'h20, 32'h0003_0000);
        rd(6'h1C, d); check("R8 clear both", d, 0);
        check("R8 irq low", {31'd0, irq}, 0);

        // R9 mask timeout, R8 selective clear
        wr(6'h18, 32'h2);
        end_stream(30);
        rd(6'h1C, d); check("R9 masked status", d, 32'h0100_0300);
        wr(6'h20, 32'h0001_0000);
        rd(6'h1C, d); check("R8 rcv only cleared", d, 32'h0000_0200);
        check("R9 masked irq low", {31'd0, irq}, 0);
        drain("R9");
        wr(6'h20, 32'h0007_0000);
        wr(6'h18, 0);

        // R10 threshold of three symbols
        wr(6'h04, {16'(MAXW), 2'd0, 6'd2, 1'b1, 7'd0});
        send_sym(20, 20);
        send_sym(30, 20);
        ir_in = 0; idle(10); ir_in = 1;
        idle(10);
        rd(6'h1C, d); check("R10 below threshold", d, 0);
        idle(MAXW * T + 20);
        expect_word(16'd1, 16'(MAXW));
        rd(6'h1C, d); check("R10 at threshold", d, 32'h0300_0300);
        drain("R10");
        wr(6'h20, 32'h0007_0000);
        wr(6'h04, {16'(MAXW), 2'd0, 6'd0, 1'b1, 7'd0});

        // R6 R7 overflow keeps contents, clear gated by empty FIFO
        for (int i = 0; i < DEPTH; i++) send_sym((i + 1) * T + 3, 25 + (i % 5) * T);
        end_stream(50);
        rd(6'h1C, d); check("R6 status ovf", d, 32'h0700_0700);
        wr(6'h20, 32'h0004_0000);
        rd(6'h1C, d); check("R7 ovf clear ignored", d, 32'h0700_0700);
        drain("R6");
        wr(6'h20, 32'h0004_0000);
        rd(6'h1C, d); check("R7 ovf cleared", d, 32'h0300_0300);
        wr(6'h20, 32'h0003_0000);
        check("R8 irq final", {31'd0, irq}, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule